// File: doc/BRIEF.md
# Operate Unit with Register File and NZP Flags

This block carries out the register-to-register arithmetic and logic instructions of a small 16-bit load/store processor. It contains eight 16-bit general registers. It decodes a 16-bit instruction word into one of three operations: two's-complement add, bitwise and, and bitwise complement. The result is written back to a destination register at the next rising clock edge. Add and and take their second operand either from a register or from a 5-bit immediate field that is sign-extended to 16 bits. A separate write port lets the memory side of the processor deposit load results into the same register file.

Every register write, from either source, moves a three-state flag machine. The state machine has three states, named NEG, ZERO and POS, and exactly one of them is active at any time. On each write it takes the transition chosen by the written value: a set sign bit leads to NEG, an all-zero value leads to ZERO, and any other value leads to POS. When no write occurs, the state does not change. Reset places the machine in ZERO. A read port with its own address shows any register's contents without side effects.

Top module: `opu_core`

## Requirements
- R1: After reset all eight registers read 0x0000, and the flags show zero only (flag_z=1, flag_n=0, flag_p=0).
- R2: Opcode bits [15:12]=0001 with bit 5=0 writes the register named by [11:9] with the sum of the registers named by [8:6] and [2:0], modulo 2^16 (overflow wraps).
- R3: With bit 5=1, add and and use bits [4:0] as a signed immediate, sign-extended to 16 bits, in place of the second register.
- R4: Opcode 0101 writes the destination with the bitwise and of its two operands, in register mode or immediate mode.
- R5: Opcode 1001 writes the destination with the bitwise complement of the register named by [8:6]. The source and the destination may be the same register.
- R6: After any register write, exactly one flag is set: N when bit 15 of the written value is 1, Z when the value is zero, P otherwise.
- R7: When ld_we is 1, ld_data is written to register ld_addr and the flags follow ld_data as in R6.
- R8: When a valid operate instruction and ld_we occur in the same cycle, the operate result is written and sets the flags, and the load write is discarded.
- R9: When instr_valid is 0, or the opcode is none of 0001, 0101 or 1001, and ld_we is 0, no register changes and the flags hold.
- R10: A write takes effect at the rising edge on which it is presented. Before that edge, rd_data still shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| ld_we | input | 1 | Load-result write enable |
| ld_addr | input | 3 | Load-result destination register |
| ld_data | input | 16 | Load-result value |
| rd_addr | input | 3 | Observation read address |
| rd_data | output | 16 | Contents of register rd_addr |
| flag_n | output | 1 | Last written value was negative |
| flag_z | output | 1 | Last written value was zero |
| flag_p | output | 1 | Last written value was strictly positive |

## Verification
Add is tried with small positive operands, with a positive-plus-positive case that crosses into the sign bit, and with a case that wraps to zero. These three cases separate correct 16-bit wrapping from a bad carry and also drive all three flag transitions. Immediates of -5, +15 and -16 separate proper sign extension from zero extension and from a truncated field. And is tried with masks of all ones, all zeros and mixed bits. Complement is tried in place and across registers. Simultaneous load and operate writes, to the same register and to different registers, show which write wins. Undefined opcodes, including one that differs from the complement opcode by a single bit, show that the decode is exact.

// File: rtl/opu_pkg.sv
package opu_pkg;
    localparam int DATA_W = 16;
    localparam int NREG   = 8;
    localparam int RA_W   = $clog2(NREG);
    localparam int IMM_W  = 5;

    typedef enum logic [3:0] {
        OPC_ADD = 4'b0001,
        OPC_AND = 4'b0101,
        OPC_NOT = 4'b1001
    } opc_e;

    typedef enum logic [1:0] {
        FL_NEG,
        FL_ZERO,
        FL_POS
    } flag_state_e;

    typedef struct packed {
        logic [3:0]   opc;
        logic [2:0]   dst;
        logic [2:0]   src1;
        logic         imm_sel;
        logic [4:0]   low;
    } op_word_t;
endpackage

// File: rtl/opu_regfile.sv
module opu_regfile
    import opu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NREG,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_obs,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    output logic [DW-1:0] rdata_obs
);
    logic [DW-1:0] cells [NR];

    for (genvar gi = 0; gi < NR; gi++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cells[gi] <= '0;
            end else if (we && (waddr == AW'(gi))) begin
                cells[gi] <= wdata;
            end
        end
    end

    assign rdata_a   = cells[ra_a];
    assign rdata_b   = cells[ra_b];
    assign rdata_obs = cells[ra_obs];
endmodule

// File: rtl/opu_alu.sv
module opu_alu
    import opu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic [15:0]   word,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [DW-1:0] result,
    output logic          legal
);
    op_word_t      f;
    logic [DW-1:0] imm_ext;
    logic [DW-1:0] second;

    assign f       = op_word_t'(word);
    assign imm_ext = {{(DW-IW){f.low[IW-1]}}, f.low[IW-1:0]};
    assign second  = f.imm_sel ? imm_ext : opnd_b;

    always_comb begin
        result = '0;
        legal  = 1'b0;
        unique case (opc_e'(f.opc))
            OPC_ADD: begin
                result = opnd_a + second;
                legal  = 1'b1;
            end
            OPC_AND: begin
                result = opnd_a & second;
                legal  = 1'b1;
            end
            OPC_NOT: begin
                result = ~opnd_a;
                legal  = 1'b1;
            end
            default: begin
                result = '0;
                legal  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/opu_nzp.sv
module opu_nzp
    import opu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_val,
    output logic          is_neg,
    output logic          is_zero,
    output logic          is_pos
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            if (wr_val[DW-1])        state_d = FL_NEG;
            else if (wr_val == '0)   state_d = FL_ZERO;
            else                     state_d = FL_POS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_ZERO;
        else        state_q <= state_d;
    end

    always_comb begin
        is_neg  = 1'b0;
        is_zero = 1'b0;
        is_pos  = 1'b0;
        unique case (state_q)
            FL_NEG:  is_neg  = 1'b1;
            FL_ZERO: is_zero = 1'b1;
            FL_POS:  is_pos  = 1'b1;
            default: is_zero = 1'b1;
        endcase
    end
endmodule

// File: rtl/opu_core.sv
module opu_core
    import opu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NREG,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_valid,
    input  logic [15:0]   instr,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_p
);
    op_word_t      f;
    logic [DW-1:0] src_a, src_b, alu_out;
    logic          alu_legal, op_fire;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    assign f = op_word_t'(instr);

    opu_regfile #(.DW(DW), .NR(NR)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (wr_addr),
        .wdata     (wr_data),
        .ra_a      (f.src1[AW-1:0]),
        .ra_b      (f.low[AW-1:0]),
        .ra_obs    (rd_addr),
        .rdata_a   (src_a),
        .rdata_b   (src_b),
        .rdata_obs (rd_data)
    );

    opu_alu #(.DW(DW)) u_alu (
        .word   (instr),
        .opnd_a (src_a),
        .opnd_b (src_b),
        .result (alu_out),
        .legal  (alu_legal)
    );

    // Operate result takes the write port over a concurrent load.
    assign op_fire = instr_valid && alu_legal;
    assign wr_en   = op_fire || ld_we;
    assign wr_addr = op_fire ? f.dst[AW-1:0] : ld_addr;
    assign wr_data = op_fire ? alu_out : ld_data;

    opu_nzp #(.DW(DW)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_val  (wr_data),
        .is_neg  (flag_n),
        .is_zero (flag_z),
        .is_pos  (flag_p)
    );
endmodule

// File: rtl/opu_checker.sv
module opu_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_valid,
    input logic [15:0]   instr,
    input logic          ld_we,
    input logic [DW-1:0] ld_data,
    input logic          flag_n,
    input logic          flag_z,
    input logic          flag_p
);
    logic known_op;
    assign known_op = instr_valid &&
        (instr[15:12] == 4'b0001 || instr[15:12] == 4'b0101 || instr[15:12] == 4'b1001);

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_z && !flag_n && !flag_p));

    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({flag_n, flag_z, flag_p}) == 1);

    p_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !known_op) |=> (flag_z == ($past(ld_data) == '0)));

    p_load_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_we && !known_op) |=> (flag_n == $past(ld_data[DW-1])));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_we && !known_op) |=> $stable({flag_n, flag_z, flag_p}));
endmodule

bind opu_core opu_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr       (instr),
    .ld_we       (ld_we),
    .ld_data     (ld_data),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_p      (flag_p)
);

// File: tb/sim_opu_core.sv
`timescale 1ns/1ps
module sim_opu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic        ld_we = 1'b0;
    logic [2:0]  ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        flag_n, flag_z, flag_p;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    opu_core u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    localparam logic [2:0] FN = 3'b100, FZ = 3'b010, FP = 3'b001;

    function automatic logic [15:0] w_rr(input logic [3:0] op, input logic [2:0] d,
                                         input logic [2:0] s1, input logic [2:0] s2);
        return {op, d, s1, 3'b000, s2};
    endfunction

    function automatic logic [15:0] w_im(input logic [3:0] op, input logic [2:0] d,
                                         input logic [2:0] s1, input logic [4:0] im);
        return {op, d, s1, 1'b1, im};
    endfunction

    task automatic tally(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reg(input logic [2:0] a, input logic [15:0] exp, input string tag);
        rd_addr = a;
        #1;
        tally(rd_data === exp, tag, rd_data, exp);
    endtask

    task automatic check_flags(input logic [2:0] exp, input string tag);
        logic [2:0] act;
        act = {flag_n, flag_z, flag_p};
        tally(act === exp, tag, {13'd0, act}, {13'd0, exp});
    endtask

    // Presents one cycle of stimulus starting at a falling edge.
    task automatic step(input logic v, input logic [15:0] w, input logic lw,
                        input logic [2:0] la, input logic [15:0] ld);
        @(negedge clk);
        instr_valid = v; instr = w; ld_we = lw; ld_addr = la; ld_data = ld;
        @(negedge clk);
        instr_valid = 1'b0; ld_we = 1'b0;
    endtask

    task automatic do_load(input logic [2:0] a, input logic [15:0] d);
        step(1'b0, 16'h0000, 1'b1, a, d);
    endtask

    task automatic do_op(input logic [15:0] w);
        step(1'b1, w, 1'b0, 3'd0, 16'h0000);
    endtask

    task automatic t_reset;
        for (int i = 0; i < 8; i++) check_reg(i[2:0], 16'h0000, "R1 reg clear");
        check_flags(FZ, "R1 flags");
    endtask

    task automatic t_loads;
        do_load(3'd1, 16'h0005); check_reg(3'd1, 16'h0005, "R7 load r1"); check_flags(FP, "R7 P");
        do_load(3'd2, 16'h8000); check_reg(3'd2, 16'h8000, "R7 load r2"); check_flags(FN, "R7 N");
        do_load(3'd3, 16'h0000); check_reg(3'd3, 16'h0000, "R7 load r3"); check_flags(FZ, "R7 Z");
    endtask

    task automatic t_add_reg;
        do_load(3'd4, 16'h0007);
        @(negedge clk);
        instr_valid = 1'b1; instr = w_rr(4'b0001, 3'd5, 3'd1, 3'd4);
        check_reg(3'd5, 16'h0000, "R10 old value before edge");
        @(negedge clk);
        instr_valid = 1'b0;
        check_reg(3'd5, 16'h000C, "R2 5+7");
        check_flags(FP, "R6 P after add");
        do_load(3'd6, 16'h7FFF);
        do_op(w_rr(4'b0001, 3'd7, 3'd6, 3'd1));
        check_reg(3'd7, 16'h8004, "R2 into sign bit");
        check_flags(FN, "R6 N after add");
        do_op(w_rr(4'b0001, 3'd7, 3'd2, 3'd2));
        check_reg(3'd7, 16'h0000, "R2 wrap to zero");
        check_flags(FZ, "R6 Z after add");
    endtask

    task automatic t_add_imm;
        do_op(w_im(4'b0001, 3'd0, 3'd1, 5'b11011));
        check_reg(3'd0, 16'h0000, "R3 5+(-5)");
        check_flags(FZ, "R3 Z");
        do_op(w_im(4'b0001, 3'd0, 3'd1, 5'b01111));
        check_reg(3'd0, 16'h0014, "R3 5+15");
        do_op(w_im(4'b0001, 3'd0, 3'd1, 5'b10000));
        check_reg(3'd0, 16'hFFF5, "R3 5+(-16)");
        check_flags(FN, "R3 N");
    endtask

    task automatic t_and;
        do_load(3'd3, 16'hF0F0);
        do_load(3'd4, 16'h0FF0);
        do_op(w_rr(4'b0101, 3'd5, 3'd3, 3'd4));
        check_reg(3'd5, 16'h00F0, "R4 and reg");
        check_flags(FP, "R4 P");
        do_op(w_im(4'b0101, 3'd5, 3'd3, 5'b00000));
        check_reg(3'd5, 16'h0000, "R4 and #0");
        check_flags(FZ, "R4 Z");
        do_op(w_im(4'b0101, 3'd6, 3'd3, 5'b11111));
        check_reg(3'd6, 16'hF0F0, "R4 and #-1");
        check_flags(FN, "R4 N");
        do_op(w_im(4'b0101, 3'd6, 3'd4, 5'b10000));
        check_reg(3'd6, 16'h0FF0, "R4 and #-16");
    endtask

    task automatic t_not;
        do_op({4'b1001, 3'd3, 3'd3, 6'b111111});
        check_reg(3'd3, 16'h0F0F, "R5 not in place");
        check_flags(FP, "R5 P");
        do_op({4'b1001, 3'd2, 3'd7, 6'b111111});
        check_reg(3'd2, 16'hFFFF, "R5 not of zero");
        check_flags(FN, "R5 N");
    endtask

    task automatic t_collide;
        step(1'b1, w_im(4'b0001, 3'd4, 3'd4, 5'b00001), 1'b1, 3'd4, 16'h8000);
        check_reg(3'd4, 16'h0FF1, "R8 same reg op wins");
        check_flags(FP, "R8 flags from op");
        step(1'b1, w_im(4'b0001, 3'd0, 3'd1, 5'b00000), 1'b1, 3'd6, 16'hAAAA);
        check_reg(3'd0, 16'h0005, "R8 op written");
        check_reg(3'd6, 16'h0FF0, "R8 load discarded");
        check_flags(FP, "R8 flags not from load");
    endtask

    task automatic t_ignore;
        do_load(3'd7, 16'h9000);
        do_op(w_rr(4'b0010, 3'd7, 3'd1, 3'd1));
        check_reg(3'd7, 16'h9000, "R9 undefined opcode");
        check_flags(FN, "R9 flags hold");
        step(1'b0, w_im(4'b0001, 3'd1, 3'd1, 5'b00001), 1'b0, 3'd0, 16'h0000);
        check_reg(3'd1, 16'h0005, "R9 valid low");
        do_op({4'b1101, 3'd1, 3'd1, 6'b111111});
        check_reg(3'd1, 16'h0005, "R9 near-miss opcode");
        check_flags(FN, "R9 flags hold after near miss");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_loads();
        t_add_reg();
        t_add_imm();
        t_and();
        t_not();
        t_collide();
        t_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule